// File: doc/BRIEF.md
# Serial Receiver with Error Lockout

This block takes an asynchronous serial line and turns it into bytes. A frame is one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A programmable divider sets the oversampling tick. Each bit lasts sixteen ticks and is sampled at its centre. A clean byte is placed in a holding register and raises a ready flag. The flag is cleared in one of two ways: software writes a zero to it, or a DMA-style consumer takes the byte through a valid/ready handshake.

There are three error flags: overrun, parity and framing. Once any of them is set, the receiver stops accepting frames. It starts again only after software has cleared all three. An interrupt pulse marks each new byte, and a level error interrupt stays high while any error flag is set.

For back-pressure, the DMA valid output is the ready flag itself. Valid stays high, and the byte stays unchanged, until the consumer raises ready or software clears the flag. A byte that completes while valid is still high does not wait. It is dropped and flagged as an overrun.

Top module: `uart_rx_lockout`

## Requirements
- R1: After reset, the status is 0, the data register is 0 and both interrupts are low.
- R2: The oversampling tick fires every baud_div_i+1 clocks, and one bit lasts 16 ticks. A frame with the correct parity and a high stop bit, arriving while status bit 0 is clear, loads its eight bits (first received = bit 0) into rx_data_o and sets status bit 0 (data ready).
- R3: rx_irq_o is high for exactly one clock in the cycle where status bit 0 goes from 0 to 1.
- R4: If a frame completes while status bit 0 is still 1, status bit 1 (overrun) is set and rx_data_o keeps the earlier byte.
- R5: With par_en_i=1, the parity bit is checked. par_odd_i=0 means the data bits plus the parity bit must contain an even number of ones; par_odd_i=1 means an odd number. On a mismatch, status bit 2 is set and the byte is discarded.
- R6: A stop bit sampled as 0 sets status bit 3 (framing) and discards the byte.
- R7: err_irq_o is high whenever any of status bits 3..1 is set.
- R8: While any of status bits 3..1 is set, start edges are ignored and no frame is received. Reception resumes once all three are clear.
- R9: A write (wr_i=1) clears each status bit whose wr_data_i bit is 0. A bit written as 1 is left unchanged.
- R10: A DMA handshake (dma_valid_o and dma_ready_i both high) clears status bit 0 and leaves rx_data_o unchanged. dma_valid_o equals status bit 0.
- R11: While rx_en_i is 0, no new frame starts. A frame already in progress when rx_en_i falls is still completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idles high |
| baud_div_i | input | 16 | Clocks per oversampling tick, minus one |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| wr_i | input | 1 | Status write strobe |
| wr_data_i | input | 4 | Status write data; a 0 bit clears the matching flag |
| dma_ready_i | input | 1 | DMA consumer takes the byte |
| dma_valid_o | output | 1 | A byte is waiting for the consumer |
| rx_data_o | output | 8 | Receive data register |
| sts_o | output | 4 | Status flags: bit 3 framing, bit 2 parity, bit 1 overrun, bit 0 ready |
| rx_irq_o | output | 1 | One-clock pulse when a new byte arrives |
| err_irq_o | output | 1 | High while any error flag is set |

## Verification
The hardest situation to reach is a frame that arrives during an error lockout. The bench has to leave an error flag set and then drive a complete, well-formed frame that contains a falling edge. It then confirms at the ports that the data, the ready flag and the interrupt count did not change. Directed sequences create overrun, parity and framing errors on purpose, and they also drop the enable in the middle of a frame. Constrained random frames mix DMA takes, software clears, parity modes and corrupted bits, so that these cases are hit again in varied orders.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic fer;
    logic per;
    logic orer;
    logic rdy;
  } rx_status_t;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              start_ok_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              stop_bad_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BLAST = BIT_W'(DATA_W - 1);

  rx_state_e         st_q;
  logic [2:0]        sync_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [BIT_W-1:0]  bcnt_q;
  logic [DATA_W-1:0] shr_q;
  logic              pbit_q;
  logic              rx_s, fall;

  assign rx_s   = sync_q[1];
  assign fall   = sync_q[2] & ~sync_q[1];
  assign data_o = shr_q;
  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else sync_q <= {sync_q[1:0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      tcnt_q     <= '0;
      bcnt_q     <= '0;
      shr_q      <= '0;
      pbit_q     <= 1'b0;
      done_o     <= 1'b0;
      par_bad_o  <= 1'b0;
      stop_bad_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_ok_i && fall) begin
            st_q   <= ST_START;
            tcnt_q <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (tcnt_q == MID) begin
              tcnt_q <= '0;
              bcnt_q <= '0;
              st_q   <= rx_s ? ST_IDLE : ST_DATA;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (tcnt_q == LAST) begin
              tcnt_q <= '0;
              shr_q  <= {rx_s, shr_q[DATA_W-1:1]};
              bcnt_q <= bcnt_q + 1'b1;
              if (bcnt_q == BLAST) st_q <= par_en_i ? ST_PAR : ST_STOP;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            if (tcnt_q == LAST) begin
              tcnt_q <= '0;
              pbit_q <= rx_s;
              st_q   <= ST_STOP;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (tcnt_q == LAST) begin
              tcnt_q     <= '0;
              done_o     <= 1'b1;
              stop_bad_o <= ~rx_s;
              par_bad_o  <= par_en_i & ((^shr_q ^ pbit_q) != par_odd_i);
              st_q       <= ST_IDLE;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bad_i,
  input  logic              stop_bad_i,
  input  logic              wr_i,
  input  logic [3:0]        wr_data_i,
  input  logic              take_i,
  output rx_status_t        sts_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_irq_o
);
  rx_status_t clr, nxt;
  logic       good;

  assign clr = wr_i ? rx_status_t'(~wr_data_i) : '0;

  always_comb begin
    nxt      = sts_o & ~clr;
    nxt.rdy  = nxt.rdy & ~take_i;
    good     = done_i & ~par_bad_i & ~stop_bad_i & ~nxt.rdy;
    if (done_i) begin
      nxt.fer  = nxt.fer | stop_bad_i;
      nxt.per  = nxt.per | par_bad_i;
      nxt.orer = nxt.orer | nxt.rdy;
      if (good) nxt.rdy = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_o    <= '0;
      data_o   <= '0;
      rx_irq_o <= 1'b0;
    end else begin
      sts_o    <= nxt;
      rx_irq_o <= good;
      if (good) data_o <= data_i;
    end
  end
endmodule

// File: rtl/uart_rx_lockout.sv
module uart_rx_lockout
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              wr_i,
  input  logic [3:0]        wr_data_i,
  input  logic              dma_ready_i,
  output logic              dma_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [3:0]        sts_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  rx_status_t        sts;
  logic              tick, done, par_bad, stop_bad, rx_busy, start_ok;
  logic [DATA_W-1:0] frame;

  assign start_ok    = rx_en_i & ~(sts.orer | sts.per | sts.fer);
  assign sts_o       = sts;
  assign dma_valid_o = sts.rdy;
  assign err_irq_o   = sts.orer | sts.per | sts.fer;

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick)
  );

  uart_rx_deser #(.DATA_W(DATA_W), .OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
    .start_ok_i(start_ok), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .done_o(done), .data_o(frame), .par_bad_o(par_bad),
    .stop_bad_o(stop_bad), .busy_o(rx_busy)
  );

  uart_rx_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .done_i(done), .data_i(frame),
    .par_bad_i(par_bad), .stop_bad_i(stop_bad), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .take_i(dma_valid_o & dma_ready_i),
    .sts_o(sts), .data_o(rx_data_o), .rx_irq_o(rx_irq_o)
  );
endmodule

// File: rtl/uart_rx_lockout_chk.sv
module uart_rx_lockout_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic              dma_ready_i,
  input logic              dma_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic [3:0]        sts_o,
  input logic              rx_irq_o,
  input logic              busy
);
  AST_IRQ_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[0]) |-> rx_irq_o);  // R3
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o[1]) |-> $stable(rx_data_o));  // R4
  AST_DMA_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid_o && dma_ready_i) |=> (!sts_o[0] || rx_irq_o));  // R10
  AST_ERROR_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_o[3:1] != 3'b000) |-> !busy);  // R8
  AST_ENABLE_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en_i && !busy) |=> !busy);  // R11
endmodule

bind uart_rx_lockout uart_rx_lockout_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .dma_ready_i(dma_ready_i),
  .dma_valid_o(dma_valid_o), .rx_data_o(rx_data_o), .sts_o(sts_o),
  .rx_irq_o(rx_irq_o), .busy(rx_busy)
);

// File: tb/uart_rx_lockout_test.sv
module uart_rx_lockout_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rx_en = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] wr_data = 4'hF;
  logic       dma_ready = 1'b0;
  logic       dma_valid, rx_irq, err_irq;
  logic [7:0] rx_data;
  logic [3:0] sts;

  int checks = 0, fails = 0, irq_cnt = 0;
  logic [3:0] m_sts = '0;
  logic [7:0] m_data = '0;
  int m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_lockout uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(16'(DIV)),
    .rx_en_i(rx_en), .par_en_i(par_en), .par_odd_i(par_odd),
    .wr_i(wr), .wr_data_i(wr_data), .dma_ready_i(dma_ready),
    .dma_valid_o(dma_valid), .rx_data_o(rx_data), .sts_o(sts),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  always @(negedge clk) if (rx_irq) irq_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return ^d ^ odd;
  endfunction

  task automatic model_frame(input logic [7:0] d, input logic pflip, input logic sbad);
    if (m_sts[3:1] != 3'b000) return;
    if (pflip || sbad || m_sts[0]) begin
      m_sts[3] = m_sts[3] | sbad;
      m_sts[2] = m_sts[2] | pflip;
      m_sts[1] = m_sts[1] | m_sts[0];
    end else begin
      m_data = d;
      m_sts[0] = 1'b1;
      m_irq++;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic pflip, input logic sbad);
    @(negedge clk) rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (par_en) begin
      rx = par_bit(d, par_odd) ^ pflip;
      repeat (BIT) @(negedge clk);
    end
    rx = ~sbad;
    repeat (BIT) @(negedge clk);
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic write(input logic [3:0] v);
    @(negedge clk) begin wr = 1'b1; wr_data = v; end
    @(negedge clk) begin wr = 1'b0; wr_data = 4'hF; end
    for (int i = 0; i < 4; i++) if (!v[i]) m_sts[i] = 1'b0;
  endtask

  task automatic dma_take();
    @(negedge clk) dma_ready = 1'b1;
    @(negedge clk) dma_ready = 1'b0;
    m_sts[0] = 1'b0;
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    chk({req, " status"}, 32'(sts), 32'(m_sts));
    chk({req, " data"}, 32'(rx_data), 32'(m_data));
    chk({req, " err_irq R7"}, 32'(err_irq), 32'(m_sts[3:1] != 3'b000));
    chk({req, " dma_valid R10"}, 32'(dma_valid), 32'(m_sts[0]));
    chk({req, " rx_irq count R3"}, 32'(irq_cnt), 32'(m_irq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R2 plain frame, no parity
    send(8'hA5, 1'b0, 1'b0); model_frame(8'hA5, 1'b0, 1'b0);
    check_all("R2 first frame");

    // R4 overrun keeps earlier byte
    send(8'h3C, 1'b0, 1'b0); model_frame(8'h3C, 1'b0, 1'b0);
    check_all("R4 overrun");

    // R9 writing ones changes nothing
    write(4'hF);
    check_all("R9 write ones");

    // R8 lockout: frame ignored while overrun set, even with ready cleared
    write(4'b1110);
    send(8'h81, 1'b0, 1'b0); model_frame(8'h81, 1'b0, 1'b0);
    check_all("R8 locked frame ignored");

    // R9 clear errors, R8 resume
    write(4'b0001);
    check_all("R9 clear errors");
    send(8'h81, 1'b0, 1'b0); model_frame(8'h81, 1'b0, 1'b0);
    check_all("R8 resumed");

    // R10 dma take
    dma_take();
    check_all("R10 dma take");

    // R5 parity even then odd, bad parity
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1'b0, 1'b0); model_frame(8'h07, 1'b0, 1'b0);
    check_all("R5 even parity ok");
    write(4'b1110);
    par_odd = 1'b1;
    send(8'h5A, 1'b1, 1'b0); model_frame(8'h5A, 1'b1, 1'b0);
    check_all("R5 odd parity mismatch");
    write(4'b0001);

    // R6 framing error
    send(8'hC3, 1'b0, 1'b1); model_frame(8'hC3, 1'b0, 1'b1);
    check_all("R6 framing error");
    write(4'b0001);

    // R11 enable low blocks a frame
    rx_en = 1'b0;
    send(8'h11, 1'b0, 1'b0);
    check_all("R11 disabled ignores");
    rx_en = 1'b1;

    // R11 enable dropped mid-frame still completes
    fork
      send(8'h96, 1'b0, 1'b0);
      begin repeat (3 * BIT) @(negedge clk); rx_en = 1'b0; end
    join
    model_frame(8'h96, 1'b0, 1'b0);
    rx_en = 1'b1;
    check_all("R11 mid-frame completes");

    // Random mix, R2 R3 R4 R5 R6 R10
    for (int n = 0; n < 24; n++) begin
      int act;
      logic [7:0] d;
      logic pf, sb;
      par_en  = 1'($urandom % 2);
      par_odd = 1'($urandom % 2);
      act = int'($urandom % 4);
      if (act == 0) write(4'b1110);
      else if (act == 1) dma_take();
      d  = 8'($urandom);
      pf = par_en && ($urandom % 6 == 0);
      sb = ($urandom % 8 == 0);
      send(d, pf, sb); model_frame(d, pf, sb);
      check_all("R2 random frame");
      if (m_sts[3:1] != 3'b000) begin
        write(4'b0001);
        check_all("R9 random clear");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule